// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Vectored Interrupt

This block is a single timer channel for a bus-attached peripheral. Software programs a reload value, a prescale code and a vector base over a simple register bus. The channel then counts prescaled clocks down from the reload value. Each time the count runs out, it reloads on its own and latches a pending interrupt. There is no software reload between periods, so the channel serves as a steady system tick.

A pending interrupt drives the active-low request line only while the channel's enable bit and its mask bit are both set. When the processor runs an acknowledge cycle against an active request, the block answers with an eight-bit vector: the programmed upper four bits with a fixed channel number of 8 in the lower four bits. It also signals transfer acknowledge and drops the pending bit. The processor uses that vector to reach its handler directly, without polling the sources.

Top module: `tick_vec_timer`

## Requirements
- R1: After reset, irq_n and dtack_n are high, bus_rdata is 0, and all registers are 0. The current count reads 0, which stands for a full count of 256.
- R2: The control register (address 0, bits [2:0]) sets the prescale code. Code 0 holds the count still. Codes 1 to 7 divide the clock by 4, 10, 16, 50, 64, 100 and 200 in that order.
- R3: The count steps down by one on each prescaled tick. On the tick that finds it at 1, it reloads from the data register and underflows. A reload value of 0 gives 256 ticks. Periods repeat with no further writes.
- R4: Writing the data register (address 1) while the code is nonzero changes only the reload value, and the running count goes on unchanged. Writing it while stopped also loads the count. Reading address 1 returns the current count.
- R5: An underflow sets the pending bit (read at address 5, bit 0) when the enable bit (address 3, bit 0) is set, whatever the mask bit. irq_n is low exactly while pending, enable and mask (address 4, bit 0) are all 1.
- R6: Writing 0 to the enable bit clears the pending bit in the same clock.
- R7: iack high for one clock while irq_n is low makes the block do three things one clock later: drive dtack_n low, put {vector base [7:4], 4'h8} on bus_rdata, and clear pending so that irq_n goes high. With base 0x40 the vector is 0x48.
- R8: iack while irq_n is high gets no reply: dtack_n stays high and bus_rdata stays 0.
- R9: A register access (bus_sel high for one clock) is answered one clock later with dtack_n low for one clock. A read puts its data on bus_rdata in that same clock. The vector base register (address 2) keeps bits [7:4] only.
- R10: Writing the control register restarts the prescaler phase, so the first tick comes a full divide period after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | One-clock register access strobe |
| bus_we | input | 1 | High for a write, low for a read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or interrupt vector, valid while dtack_n is low, 0 otherwise |
| iack | input | 1 | One-clock interrupt acknowledge strobe |
| dtack_n | output | 1 | Active-low transfer acknowledge |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The properties assume that bus_sel and iack each arrive as one-clock strobes and never in the same clock, as they would from a single bus master. The bench drives every access through tasks that raise a strobe for exactly one clock and wait for the reply before starting the next access. The reference model then predicts the outputs on every clock from those legal cycles alone, including an acknowledge that lands while no request is active.

// File: rtl/tv_pkg.sv
package tv_pkg;
    localparam int DW     = 8;
    localparam int CODE_W = 3;
    localparam int VB_W   = 4;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_DATA  = 3'd1;
    localparam logic [2:0] A_VBASE = 3'd2;
    localparam logic [2:0] A_IEN   = 3'd3;
    localparam logic [2:0] A_IMSK  = 3'd4;
    localparam logic [2:0] A_PEND  = 3'd5;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DW-1:0]     reload;
        logic [VB_W-1:0]   vbase;
        logic              ien;
        logic              imsk;
        logic              dtack;
        logic [DW-1:0]     dout;
    } regs_t;

    function automatic logic [7:0] div_of(input logic [CODE_W-1:0] c);
        case (c)
            3'd1:    div_of = 8'd4;
            3'd2:    div_of = 8'd10;
            3'd3:    div_of = 8'd16;
            3'd4:    div_of = 8'd50;
            3'd5:    div_of = 8'd64;
            3'd6:    div_of = 8'd100;
            3'd7:    div_of = 8'd200;
            default: div_of = 8'd1;
        endcase
    endfunction
endpackage

// File: rtl/tv_prescale.sv
module tv_prescale
    import tv_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              restart,
    output logic              tick
);
    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] last;

    always_comb begin
        last = PW'(div_of(code) - 8'd1);
        tick = (code != '0) && (pre_q == last);
        if (restart || code == '0)
            pre_d = '0;
        else if (tick)
            pre_d = '0;
        else
            pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/tv_downcount.sv
module tv_downcount #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] count,
    output logic          underflow
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        underflow = tick && (cnt_q == CW'(1));
        if (load)
            cnt_d = load_val;
        else if (underflow)
            cnt_d = reload;
        else if (tick)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/tv_irq.sv
module tv_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ien,
    input  logic imsk,
    input  logic dis_clr,
    input  logic set_ev,
    input  logic ack_ev,
    output logic pend,
    output logic irq_n
);
    logic pend_d, pend_q;

    always_comb begin
        if (dis_clr)
            pend_d = 1'b0;
        else if (set_ev && ien)
            pend_d = 1'b1;
        else if (ack_ev)
            pend_d = 1'b0;
        else
            pend_d = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend  = pend_q;
    assign irq_n = ~(pend_q & ien & imsk);
endmodule

// File: rtl/tick_vec_timer.sv
module tick_vec_timer
    import tv_pkg::*;
#(
    parameter int CHAN_NUM = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          iack,
    output logic          dtack_n,
    output logic          irq_n
);
    localparam int LOW_W = DW - VB_W;
    localparam logic [LOW_W-1:0] CHAN_BITS = LOW_W'(CHAN_NUM);

    regs_t st_d, st_q;

    logic              wr, rd, ack, restart, load, dis_clr;
    logic              tick, underflow, pend;
    logic [DW-1:0]     count, rval, vector;
    logic [CODE_W-1:0] code;
    logic [VB_W-1:0]   vbase;
    logic              ien, imsk;

    assign code  = st_q.code;
    assign vbase = st_q.vbase;
    assign ien   = st_q.ien;
    assign imsk  = st_q.imsk;

    tv_prescale #(.PW(8)) u_pre (
        .clk(clk), .rst_n(rst_n), .code(st_q.code),
        .restart(restart), .tick(tick)
    );

    tv_downcount #(.CW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_val(bus_wdata), .reload(st_q.reload),
        .count(count), .underflow(underflow)
    );

    tv_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ien(st_q.ien), .imsk(st_q.imsk),
        .dis_clr(dis_clr), .set_ev(underflow), .ack_ev(ack),
        .pend(pend), .irq_n(irq_n)
    );

    always_comb begin
        wr      = bus_sel && bus_we;
        rd      = bus_sel && !bus_we;
        ack     = iack && !irq_n;
        restart = wr && (bus_addr == A_CTRL);
        load    = wr && (bus_addr == A_DATA) && (st_q.code == '0);
        dis_clr = wr && (bus_addr == A_IEN) && !bus_wdata[0];
        vector  = {st_q.vbase, CHAN_BITS};

        case (bus_addr)
            A_CTRL:  rval = DW'(st_q.code);
            A_DATA:  rval = count;
            A_VBASE: rval = {st_q.vbase, {LOW_W{1'b0}}};
            A_IEN:   rval = DW'(st_q.ien);
            A_IMSK:  rval = DW'(st_q.imsk);
            A_PEND:  rval = DW'(pend);
            default: rval = '0;
        endcase

        st_d = st_q;
        if (wr) begin
            case (bus_addr)
                A_CTRL:  st_d.code   = bus_wdata[CODE_W-1:0];
                A_DATA:  st_d.reload = bus_wdata;
                A_VBASE: st_d.vbase  = bus_wdata[DW-1:LOW_W];
                A_IEN:   st_d.ien    = bus_wdata[0];
                A_IMSK:  st_d.imsk   = bus_wdata[0];
                default: ;
            endcase
        end
        st_d.dtack = bus_sel || ack;
        if (ack)
            st_d.dout = vector;
        else if (rd)
            st_d.dout = rval;
        else
            st_d.dout = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.dout;
    assign dtack_n   = ~st_q.dtack;
endmodule

// File: rtl/tv_checker.sv
module tv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       iack,
    input logic       dtack_n,
    input logic       irq_n,
    input logic [3:0] vbase,
    input logic [2:0] code,
    input logic [7:0] count,
    input logic       ien,
    input logic       imsk,
    input logic       pend,
    input logic       underflow
);
    p_ack_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !irq_n) |=> (!dtack_n && bus_rdata == {$past(vbase), 4'h8}));

    p_ack_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !irq_n && !underflow) |=> irq_n);

    p_no_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && irq_n && !bus_sel) |=> (dtack_n && bus_rdata == 8'h00));

    p_dis_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 3'd3 && !bus_wdata[0]) |=> !pend);

    p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (pend && ien && imsk));

    p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'd0 && !bus_sel) |=> $stable(count));

    p_bus_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> !dtack_n);

    p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && ien && !(bus_sel && bus_addr == 3'd3)) |=> pend);
endmodule

bind tick_vec_timer tv_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .iack(iack), .dtack_n(dtack_n), .irq_n(irq_n), .vbase(vbase),
    .code(code), .count(count), .ien(ien), .imsk(imsk), .pend(pend),
    .underflow(underflow)
);

// File: tb/tick_vec_timer_bench.sv
module tick_vec_timer_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       iack = 1'b0;
    logic [7:0] bus_rdata;
    logic       dtack_n, irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    tick_vec_timer u_tick_vec_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .iack(iack), .dtack_n(dtack_n), .irq_n(irq_n)
    );

    // behavioural reference model, count held as 1..256
    int m_code, m_reload, m_cnt, m_pre, m_vb, m_ien, m_imsk, m_pend, m_dt, m_dout;

    function automatic int mdiv(int c);
        case (c)
            1: return 4;   2: return 10;  3: return 16;  4: return 50;
            5: return 64;  6: return 100; 7: return 200; default: return 1;
        endcase
    endfunction

    function automatic int mread(int a);
        case (a)
            0: return m_code;
            1: return m_cnt % 256;
            2: return m_vb * 16;
            3: return m_ien;
            4: return m_imsk;
            5: return m_pend;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_reload = 0; m_cnt = 256; m_pre = 0; m_vb = 0;
            m_ien = 0; m_imsk = 0; m_pend = 0; m_dt = 0; m_dout = 0;
        end else begin
            bit wr, ack, tick, under;
            int n_cnt, n_pre, n_pend, n_dout, a, w;
            a = int'(bus_addr); w = int'(bus_wdata);
            wr = bus_sel && bus_we;
            ack = iack && (m_pend != 0) && (m_ien != 0) && (m_imsk != 0);
            tick = (m_code != 0) && (m_pre == mdiv(m_code) - 1);
            under = tick && (m_cnt == 1);
            if (wr && a == 1 && m_code == 0) n_cnt = (w == 0) ? 256 : w;
            else if (under) n_cnt = (m_reload == 0) ? 256 : m_reload;
            else if (tick) n_cnt = m_cnt - 1;
            else n_cnt = m_cnt;
            if ((wr && a == 0) || m_code == 0 || tick) n_pre = 0;
            else n_pre = m_pre + 1;
            if (wr && a == 3 && (w % 2) == 0) n_pend = 0;
            else if (under && m_ien != 0) n_pend = 1;
            else if (ack) n_pend = 0;
            else n_pend = m_pend;
            if (ack) n_dout = m_vb * 16 + 8;
            else if (bus_sel && !bus_we) n_dout = mread(a);
            else n_dout = 0;
            m_dt = (bus_sel || ack) ? 1 : 0;
            if (wr) begin
                case (a)
                    0: m_code = w % 8;
                    1: m_reload = w;
                    2: m_vb = w / 16;
                    3: m_ien = w % 2;
                    4: m_imsk = w % 2;
                    default: ;
                endcase
            end
            m_cnt = n_cnt; m_pre = n_pre; m_pend = n_pend; m_dout = n_dout;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit m_irq_n;
            m_irq_n = !((m_pend != 0) && (m_ien != 0) && (m_imsk != 0));
            check(irq_n == m_irq_n, "R5", "irq_n vs model", int'(irq_n), int'(m_irq_n));
            check(dtack_n == !m_dt[0], "R9", "dtack_n vs model", int'(dtack_n), int'(!m_dt[0]));
            check(int'(bus_rdata) == m_dout, "R7", "bus_rdata vs model", int'(bus_rdata), m_dout);
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic do_ack(output int vec, output bit dt_n);
        @(negedge clk);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
        vec = int'(bus_rdata);
        dt_n = dtack_n;
    endtask

    task automatic wait_irq(input int limit, output int cyc);
        cyc = 0;
        while (irq_n && cyc < limit) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=0x1 expected=0x0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, c, c2;
        bit dn;
        repeat (3) @(negedge clk);
        check(irq_n == 1'b1, "R1", "irq_n after reset", int'(irq_n), 1);
        check(dtack_n == 1'b1, "R1", "dtack_n after reset", int'(dtack_n), 1);
        rst_n = 1'b1;
        rd_reg(3'd1, v);
        check(v == 0, "R1", "count after reset", v, 0);
        rd_reg(3'd0, v);
        check(v == 0, "R1", "ctrl after reset", v, 0);

        // R9: vector base keeps upper bits only
        wr_reg(3'd2, 8'h4F);
        rd_reg(3'd2, v);
        check(v == 8'h40, "R9", "vector base readback", v, 8'h40);

        // R3 / R5: reload 3, divide by 4, enabled and unmasked
        wr_reg(3'd1, 8'd3);
        wr_reg(3'd3, 8'd1);
        wr_reg(3'd4, 8'd1);
        wr_reg(3'd0, 8'd1);
        wait_irq(40, c);
        check(c > 0 && c < 20, "R3", "first period cycles", c, 12);
        do_ack(v, dn);
        check(v == 8'h48, "R7", "vector on acknowledge", v, 8'h48);
        check(dn == 1'b0, "R7", "dtack on acknowledge", int'(dn), 0);
        check(irq_n == 1'b1, "R7", "irq_n after acknowledge", int'(irq_n), 1);

        // R8: acknowledge with no request
        do_ack(v, dn);
        check(dn == 1'b1, "R8", "dtack without request", int'(dn), 1);
        check(v == 0, "R8", "data without request", v, 0);

        // R3: repeats without software reload
        wait_irq(40, c);
        check(irq_n == 1'b0, "R3", "second period fires", int'(irq_n), 0);

        // R5: masked pending stays latched
        wr_reg(3'd4, 8'd0);
        check(irq_n == 1'b1, "R5", "irq_n while masked", int'(irq_n), 1);
        repeat (30) @(negedge clk);
        rd_reg(3'd5, v);
        check(v == 1, "R5", "pending while masked", v, 1);
        wr_reg(3'd4, 8'd1);
        check(irq_n == 1'b0, "R5", "irq_n after unmask", int'(irq_n), 0);

        // R6: disable clears pending
        wr_reg(3'd3, 8'd0);
        rd_reg(3'd5, v);
        check(v == 0, "R6", "pending after disable", v, 0);
        check(irq_n == 1'b1, "R6", "irq_n after disable", int'(irq_n), 1);
        wr_reg(3'd3, 8'd1);

        // R4: data write while running changes only the reload
        rd_reg(3'd1, c);
        wr_reg(3'd1, 8'd7);
        rd_reg(3'd1, c2);
        check(c2 != 7 || c == 7 || c == 8, "R4", "count not loaded while running", c2, c);
        wait_irq(60, c);
        do_ack(v, dn);
        wait_irq(60, c);
        check(c > 20 && c < 35, "R4", "new reload period", c, 28);
        do_ack(v, dn);

        // R2: stop holds the count; stopped write loads it
        wr_reg(3'd0, 8'd0);
        rd_reg(3'd1, c);
        repeat (50) @(negedge clk);
        rd_reg(3'd1, c2);
        check(c2 == c, "R2", "count held when stopped", c2, c);
        wr_reg(3'd1, 8'd2);
        rd_reg(3'd1, v);
        check(v == 2, "R4", "stopped write loads count", v, 2);

        // R2 / R10: divide by 200, reload 2
        wr_reg(3'd0, 8'd7);
        wait_irq(1000, c);
        check(c > 380 && c < 420, "R10", "divide-by-200 period", c, 400);
        do_ack(v, dn);

        // R3: reload 0 gives 256 ticks
        wr_reg(3'd0, 8'd0);
        wr_reg(3'd1, 8'd0);
        wr_reg(3'd0, 8'd1);
        wait_irq(2000, c);
        check(c > 1000 && c < 1040, "R3", "full-count period", c, 1024);
        do_ack(v, dn);
        check(v == 8'h48, "R7", "vector second time", v, 8'h48);

        repeat (20) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule